// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream (a bit clock, a word clock that marks left and right halves, and one data line) into parallel samples. Each frame yields a 24-bit two's-complement left sample and a 24-bit right sample. The two samples are handed over together to a separate system clock domain, and a one-cycle valid pulse marks them there.

A 3-bit framing code picks one of six framings. Right-justified words of 16, 20 or 24 bits end on the last bit clock of their half-frame. A 24-bit left-justified word starts on the first bit clock of its half. I2S words of 16 or 24 bits start one bit clock after the word-clock edge. A polarity input picks which word-clock level carries the left channel. All deserialising runs on the bit clock. The finished pair crosses into the system domain through a toggle that is passed through a short flop chain.

Top module: `audio_rx_top`

## Requirements
- R1: `sdata` and `lrck` are sampled on the rising edge of `bckClk`. Words are sent MSB first and are delivered unchanged as two's complement.
- R2: The framing code `fmtSel` selects right-justified words: 3'b000 for 16 bits, 3'b001 for 20 bits and 3'b010 for 24 bits. The word's LSB is on the last rising edge of `bckClk` before the `lrck` transition, and any bits that precede the word in that half are ignored.
- R3: `fmtSel`=3'b011 selects a 24-bit left-justified word. Its MSB is on the first rising edge of `bckClk` that samples the new `lrck` level.
- R4: `fmtSel`=3'b100 selects a 16-bit I2S word and 3'b101 a 24-bit I2S word. The MSB is on the second rising edge of `bckClk` after the `lrck` transition.
- R5: A word shorter than 24 bits appears in bits [23:24-N] of its output, and its remaining low bits are zero.
- R6: The reserved codes 3'b110 and 3'b111 produce zero left and right samples.
- R7: With `lrPolarity`=0, `lrck` high carries the left channel. With `lrPolarity`=1, `lrck` low carries the left channel.
- R8: A pair is issued only after a left word and the right word that follows it are both complete. A right word with no left word before it since the last pair produces no output.
- R9: Each pair raises `sampleValid` for exactly one `sysClk` cycle. `leftSample` and `rightSample` change only in that cycle and hold their values until the next pulse.
- R10: In left-justified and I2S framings, bit clocks beyond the word inside a half-frame do not affect the sample.
- R11: While `rstN` is low, and after its release until the first pair, `sampleValid` is 0 and both samples are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that receives the samples |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| bckClk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word clock that marks the left and right halves |
| sdata | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 3 | Framing code |
| lrPolarity | input | 1 | Selects which `lrck` level carries the left channel |
| leftSample | output | 24 | Left sample, system domain |
| rightSample | output | 24 | Right sample, system domain |
| sampleValid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The bench builds the block with its defaults: 24-bit samples and a two-stage synchroniser. With these values all six framing codes and both reserved codes can be driven from the ports. Half-frames are sent with exactly 24 bit clocks and with 32 bit clocks. The longer halves put random padding before right-justified words and after left-justified and I2S words, so a wrong bit-counter window or a wrong shift length shows up as corrupted samples. Each phase opens with a lone right half so that R8 is checked on a word that must be dropped.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  localparam int FMT_W = 3;
  localparam int LEN_W = 6;

  typedef struct packed {
    logic [LEN_W-1:0] len;       // word length in bits
    logic             offset;    // bit clocks between lrck edge and MSB
    logic             rightJust; // word ends at the half-frame boundary
    logic             reserved;  // code has no framing; output zero
  } fmt_info_t;

  typedef struct packed {
    logic clear;   // restart the shifter at a word-clock edge
    logic load;    // while clearing, keep the bit sampled in this cycle
    logic shift;   // shift the current data bit in
    logic capLeft; // finished word belongs to the left channel
    logic publish; // finished word is the right one of a complete pair
  } rx_strobe_t;

  function automatic fmt_info_t decodeFmt(input logic [FMT_W-1:0] code);
    fmt_info_t info;
    info = '{len: LEN_W'(24), offset: 1'b0, rightJust: 1'b0, reserved: 1'b0};
    case (code)
      3'b000: begin info.len = LEN_W'(16); info.rightJust = 1'b1; end
      3'b001: begin info.len = LEN_W'(20); info.rightJust = 1'b1; end
      3'b010: begin info.len = LEN_W'(24); info.rightJust = 1'b1; end
      3'b011: begin info.len = LEN_W'(24); end
      3'b100: begin info.len = LEN_W'(16); info.offset = 1'b1; end
      3'b101: begin info.len = LEN_W'(24); info.offset = 1'b1; end
      default: info.reserved = 1'b1;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             bckClk,
  input  logic             rstN,
  input  logic             lrck,
  input  logic [FMT_W-1:0] fmtSel,
  input  logic             lrPolarity,
  output rx_strobe_t       stb
);

  logic             lrckQ;
  logic             armed;
  logic             leftSeen;
  logic [CNT_W-1:0] bitCnt;
  logic             lrEdge;
  logic             prevWasLeft;
  logic             inWindow;
  fmt_info_t        info;

  assign info        = decodeFmt(fmtSel);
  assign lrEdge      = (lrck != lrckQ);
  assign prevWasLeft = lrckQ ^ lrPolarity;
  assign inWindow    = (int'(bitCnt) >= int'(info.offset)) &&
                       (int'(bitCnt) <  int'(info.offset) + int'(info.len));

  always_comb begin
    stb = '0;
    if (info.rightJust) begin
      stb.shift = 1'b1;
    end else if (lrEdge) begin
      stb.clear = 1'b1;
      stb.load  = (info.offset == 1'b0);
    end else begin
      stb.shift = inWindow;
    end
    stb.capLeft = lrEdge && armed && prevWasLeft;
    stb.publish = lrEdge && armed && !prevWasLeft && leftSeen;
  end

  always_ff @(posedge bckClk or negedge rstN) begin
    if (!rstN) begin
      lrckQ    <= 1'b0;
      armed    <= 1'b0;
      leftSeen <= 1'b0;
      bitCnt   <= '1;
    end else begin
      lrckQ <= lrck;
      if (lrEdge) begin
        armed  <= 1'b1;
        bitCnt <= CNT_W'(1);
      end else if (bitCnt != '1) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
      if (stb.capLeft)      leftSeen <= 1'b1;
      else if (stb.publish) leftSeen <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_rx_dp.sv
module audio_rx_dp
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                bckClk,
  input  logic                rstN,
  input  logic                sdata,
  input  logic [FMT_W-1:0]    fmtSel,
  input  rx_strobe_t          stb,
  output logic [SAMPLE_W-1:0] pairLeft,
  output logic [SAMPLE_W-1:0] pairRight,
  output logic                pairTog
);

  logic [SAMPLE_W-1:0] shReg;
  logic [SAMPLE_W-1:0] leftHold;
  logic [SAMPLE_W-1:0] aligned;
  fmt_info_t           info;

  assign info = decodeFmt(fmtSel);

  // The newest len bits sit at the bottom; shifting left moves them to the top
  always_comb begin
    if (info.reserved) aligned = '0;
    else               aligned = shReg << (SAMPLE_W - int'(info.len));
  end

  always_ff @(posedge bckClk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      leftHold  <= '0;
      pairLeft  <= '0;
      pairRight <= '0;
      pairTog   <= 1'b0;
    end else begin
      if (stb.clear)      shReg <= stb.load ? {{(SAMPLE_W-1){1'b0}}, sdata} : '0;
      else if (stb.shift) shReg <= {shReg[SAMPLE_W-2:0], sdata};
      if (stb.capLeft) leftHold <= aligned;
      if (stb.publish) begin
        pairLeft  <= leftHold;
        pairRight <= aligned;
        pairTog   <= ~pairTog;
      end
    end
  end

endmodule

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                pairTog,
  input  logic [SAMPLE_W-1:0] pairLeft,
  input  logic [SAMPLE_W-1:0] pairRight,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid
);

  logic [SYNC_STAGES:0] togChain;
  logic                 newPair;

  assign newPair = togChain[SYNC_STAGES] ^ togChain[SYNC_STAGES-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      togChain    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      togChain    <= {togChain[SYNC_STAGES-1:0], pairTog};
      sampleValid <= newPair;
      if (newPair) begin
        leftSample  <= pairLeft;
        rightSample <= pairRight;
      end
    end
  end

endmodule

// File: rtl/audio_rx_top.sv
module audio_rx_top
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                bckClk,
  input  logic                lrck,
  input  logic                sdata,
  input  logic [2:0]          fmtSel,
  input  logic                lrPolarity,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid
);

  localparam int CNT_W = $clog2(SAMPLE_W + 2) + 1;

  rx_strobe_t          stb;
  logic [SAMPLE_W-1:0] pairLeft;
  logic [SAMPLE_W-1:0] pairRight;
  logic                pairTog;

  audio_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .bckClk(bckClk), .rstN(rstN), .lrck(lrck), .fmtSel(fmtSel),
    .lrPolarity(lrPolarity), .stb(stb)
  );

  audio_rx_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .bckClk(bckClk), .rstN(rstN), .sdata(sdata), .fmtSel(fmtSel), .stb(stb),
    .pairLeft(pairLeft), .pairRight(pairRight), .pairTog(pairTog)
  );

  audio_rx_sync #(.SAMPLE_W(SAMPLE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .sysClk(sysClk), .rstN(rstN), .pairTog(pairTog), .pairLeft(pairLeft),
    .pairRight(pairRight), .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid)
  );

endmodule

// File: rtl/audio_rx_checker.sv
module audio_rx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                sysClk,
  input logic                rstN,
  input logic [2:0]          fmtSel,
  input logic [SAMPLE_W-1:0] leftSample,
  input logic [SAMPLE_W-1:0] rightSample,
  input logic                sampleValid
);

  // R9: the valid strobe lasts one system cycle
  p_valid_pulse_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R9: samples move only together with the strobe
  p_hold_between_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));

  // R6: reserved framings yield silence
  p_reserved_zero_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    (sampleValid && fmtSel[2:1] == 2'b11) |-> (leftSample == '0 && rightSample == '0));

  // R5: 16-bit words leave the low byte clear
  p_short_pad16_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    (sampleValid && (fmtSel == 3'b000 || fmtSel == 3'b100)) |->
      (leftSample[7:0] == 8'h00 && rightSample[7:0] == 8'h00));

  // R5: 20-bit words leave the low nibble clear
  p_short_pad20_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    (sampleValid && fmtSel == 3'b001) |->
      (leftSample[3:0] == 4'h0 && rightSample[3:0] == 4'h0));

endmodule

bind audio_rx_top audio_rx_checker #(.SAMPLE_W(SAMPLE_W)) u_checker (
  .sysClk(sysClk), .rstN(rstN), .fmtSel(fmtSel), .leftSample(leftSample),
  .rightSample(rightSample), .sampleValid(sampleValid)
);

// File: tb/audio_rx_top_bench.sv
module audio_rx_top_bench;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } exp_t;

  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        bckClk = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmtSel = 3'b000;
  logic        lrPolarity = 1'b0;
  logic [23:0] leftSample;
  logic [23:0] rightSample;
  logic        sampleValid;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  logic prevValid = 1'b0;
  exp_t q[$];
  exp_t lastExp;

  always #2 sysClk = ~sysClk;

  audio_rx_top u_audio_rx_top (
    .sysClk(sysClk), .rstN(rstN), .bckClk(bckClk), .lrck(lrck), .sdata(sdata),
    .fmtSel(fmtSel), .lrPolarity(lrPolarity), .leftSample(leftSample),
    .rightSample(rightSample), .sampleValid(sampleValid)
  );

  function automatic int lenOf(input logic [2:0] f);
    case (f)
      3'b000, 3'b100: return 16;
      3'b001:         return 20;
      default:        return 24;
    endcase
  endfunction

  function automatic logic [23:0] expOf(input logic [23:0] w, input logic [2:0] f);
    logic [23:0] m;
    if (f[2:1] == 2'b11) return 24'h0;
    m = ~((24'd1 << (24 - lenOf(f))) - 24'd1);
    return w & m;
  endfunction

  task automatic sendBit(input logic lv, input logic d);
    lrck  = lv;
    sdata = d;
    #10 bckClk = 1'b1;
    #10 bckClk = 1'b0;
  endtask

  // Drive one half-frame in the current framing, padding with random bits
  task automatic sendHalf(input logic lv, input logic [23:0] w, input int halfLen);
    int len;
    int start;
    len = lenOf(fmtSel);
    for (int i = 0; i < halfLen; i++) begin
      logic b;
      b = 1'($urandom);
      if (fmtSel <= 3'b010) begin
        start = halfLen - len;
        if (i >= start) b = w[23 - (i - start)];
      end else if (fmtSel == 3'b011) begin
        if (i < 24) b = w[23 - i];
      end else if (fmtSel[2:1] == 2'b10) begin
        if (i >= 1 && i <= len) b = w[23 - (i - 1)];
      end
      sendBit(lv, b);
    end
  endtask

  task automatic sendFrame(input logic [23:0] l, input logic [23:0] r,
                           input int halfLen, input string tag);
    exp_t e;
    logic leftLv;
    leftLv = ~lrPolarity;
    e.l = expOf(l, fmtSel);
    e.r = expOf(r, fmtSel);
    e.tag = tag;
    q.push_back(e);
    lastExp = e;
    sendHalf(leftLv, l, halfLen);
    sendHalf(~leftLv, r, halfLen);
  endtask

  task automatic runPhase(input logic [2:0] f, input logic pol, input int halfLen,
                          input string tag);
    rstN = 1'b0;
    fmtSel = f;
    lrPolarity = pol;
    lrck = pol;
    repeat (3) @(posedge sysClk);
    #1 rstN = 1'b1;
    // R8: a lone right half with data must not produce a pair
    sendHalf(pol, 24'hA5A5A5, halfLen);
    sendFrame(24'h800000, 24'h7FFFFF, halfLen, tag);
    sendFrame(24'h123456, 24'hFEDCBA, halfLen, tag);
    sendFrame(24'h000001, 24'hFFFFFF, halfLen, tag);
    sendFrame(24'($urandom), 24'($urandom), halfLen, tag);
    sendHalf(~pol, 24'h0, 2);   // the edge into left closes the last right word
    repeat (40) @(posedge sysClk);
    @(negedge sysClk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8 %s: pending pairs actual=%0d expected=0", tag, q.size());
      q.delete();
    end
    checks++;
    if (leftSample !== lastExp.l || rightSample !== lastExp.r) begin
      errors++;
      $display("FAIL R9 %s: held pair actual=%h/%h expected=%h/%h", tag,
               leftSample, rightSample, lastExp.l, lastExp.r);
    end
  endtask

  // Monitor: pop the scoreboard at every valid strobe
  always @(negedge sysClk) begin
    if (rstN) begin
      if (sampleValid && prevValid) begin
        checks++;
        errors++;
        $display("FAIL R9: valid high actual=2 cycles expected=1");
      end
      if (sampleValid && !prevValid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected pair actual=%h/%h expected=none",
                   leftSample, rightSample);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (leftSample !== e.l || rightSample !== e.r) begin
            errors++;
            $display("FAIL %s: pair actual=%h/%h expected=%h/%h", e.tag,
                     leftSample, rightSample, e.l, e.r);
          end
        end
      end
    end
    prevValid <= sampleValid;
  end

  always @(posedge sysClk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge sysClk);
    @(negedge sysClk);
    checks++;   // R11: reset state
    if (sampleValid !== 1'b0 || leftSample !== 24'h0 || rightSample !== 24'h0) begin
      errors++;
      $display("FAIL R11: reset actual=%b/%h/%h expected=0/0/0",
               sampleValid, leftSample, rightSample);
    end
    #1 rstN = 1'b1;
    repeat (4) @(posedge sysClk);
    @(negedge sysClk);
    checks++;   // R11: still idle after release
    if (sampleValid !== 1'b0 || leftSample !== 24'h0) begin
      errors++;
      $display("FAIL R11: idle actual=%b/%h expected=0/0", sampleValid, leftSample);
    end
    runPhase(3'b000, 1'b0, 32, "R2 R5 rj16");
    runPhase(3'b001, 1'b0, 32, "R2 R5 rj20");
    runPhase(3'b010, 1'b0, 24, "R1 R2 rj24 exact");
    runPhase(3'b010, 1'b1, 32, "R2 R7 rj24 padded");
    runPhase(3'b011, 1'b0, 32, "R3 R10 lj24");
    runPhase(3'b011, 1'b1, 24, "R3 R7 lj24 exact");
    runPhase(3'b100, 1'b0, 32, "R4 R5 R10 i2s16");
    runPhase(3'b101, 1'b1, 32, "R4 R7 R10 i2s24");
    runPhase(3'b110, 1'b0, 32, "R6 reserved6");
    runPhase(3'b111, 1'b1, 32, "R6 reserved7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule